// File: doc/BRIEF.md
# Dual-Channel Memory Address Router

This block sits between a request source and two memory channel controllers. Each request carries the byte address of a whole 64-byte cache line. The block picks the channel that holds that line, rewrites the address into the channel's own address space, and selects the rank inside that channel with a one-hot chip-select. Each channel sees only the requests meant for it, through its own valid/ready port with one register stage.

Static configuration pins choose how addresses are spread across the channels. In interleaved mapping, neighbouring lines alternate between the channels. In linear fill, the first channel is filled before the second. In single-channel mapping, everything goes to channel 0. Each channel's capacity comes from its rank count and its per-rank size. An interleaved setting on unequal channels quietly becomes linear fill and sets a sticky flag. A request beyond the populated memory is consumed and answered with an error pulse, and it is not forwarded.

Top module: `dual_channel_addr_router`

## Requirements
- R1: In interleaved mapping (mode pins 2'b00), address bit 6 selects the channel. The local address is the input address with bit 6 removed: bits above it shift down one place and bits 5..0 are kept.
- R2: If interleaved mapping is selected but the two channel capacities differ, requests are mapped as in R3, and `map_fallback` goes high and stays high until reset.
- R3: In linear fill (mode pins 2'b01), addresses below channel 0's capacity go to channel 0 unchanged. Addresses from that capacity upward go to channel 1, with channel 0's capacity subtracted.
- R4: Linear fill works with channel 1 holding zero ranks. Every address below channel 0's capacity is then served by channel 0.
- R5: When mode bit 1 is set (2'b10 or 2'b11), every request goes to channel 0 with its address unchanged, and the populated range is channel 0's capacity alone.
- R6: A forwarded request carries exactly one chip-select bit. With two ranks, the local address bit at position log2(rank size) picks the rank (0 selects cs[0], 1 selects cs[1]). With one rank, cs[0] is always used.
- R7: A channel's capacity is its rank count times 2^log2(rank size) bytes. Rank count 0 means unpopulated, and rank count 3 counts as 2. A rank holds at least 64 bytes.
- R8: A request at or above the populated capacity is accepted (`in_ready` high) but goes to no channel. `err_pulse` is high for exactly the one cycle after acceptance.
- R9: A channel whose output is held and whose ready is low keeps its address and chip-select stable. Only a request for that channel is refused, and input order is never changed.
- R10: Configuration pins take effect only while both output stages are empty. A request accepted while a stage is still occupied uses the configuration last sampled.
- R11: Reset clears both channel valids, all chip-selects, `err_pulse` and `map_fallback`.
- R12: A request accepted at a clock edge is presented on its channel port immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 00 interleaved, 01 linear fill, 1x single channel |
| cfg_ch0_ranks | input | 2 | Channel 0 rank count (0..2, 3 counts as 2) |
| cfg_ch0_rank_log2 | input | LOG_W | Channel 0 log2 of rank size in bytes |
| cfg_ch1_ranks | input | 2 | Channel 1 rank count |
| cfg_ch1_rank_log2 | input | LOG_W | Channel 1 log2 of rank size in bytes |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle |
| in_addr | input | ADDR_W | Request byte address |
| ch0_valid | output | 1 | Channel 0 request valid |
| ch0_ready | input | 1 | Channel 0 takes the request |
| ch0_addr | output | ADDR_W | Channel 0 local address |
| ch0_cs | output | 2 | Channel 0 one-hot rank chip-select |
| ch1_valid | output | 1 | Channel 1 request valid |
| ch1_ready | input | 1 | Channel 1 takes the request |
| ch1_addr | output | ADDR_W | Channel 1 local address |
| ch1_cs | output | 2 | Channel 1 one-hot rank chip-select |
| err_pulse | output | 1 | Out-of-range request was consumed |
| map_fallback | output | 1 | Sticky: interleaving refused for unequal channels |

## Verification
Channel outputs and the error pulse both come from a single register, so each is due one cycle after the edge that accepts the request. `map_fallback` is registered too and also appears one cycle after the mismatching configuration is seen. `in_ready` is combinational and is checked in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples at the following falling edge, so every result is read half a period after the rising edge that produced it. Results that must persist, such as a stalled channel and the error pulse dropping again, are read at further falling edges, one per cycle.

// File: rtl/dcar_pkg.sv
package dcar_pkg;

  typedef enum logic [1:0] {
    MAP_INTLV  = 2'd0,
    MAP_LINEAR = 2'd1,
    MAP_SINGLE = 2'd2
  } map_e;

  // Mode pins to mapping: bit 1 wins, then bit 0.
  function automatic map_e map_from_pins(input logic [1:0] m);
    if (m[1])      return MAP_SINGLE;
    else if (m[0]) return MAP_LINEAR;
    else           return MAP_INTLV;
  endfunction

  // Rank count pins: 3 is treated as 2.
  function automatic logic [1:0] clip_ranks(input logic [1:0] r);
    return (r == 2'd3) ? 2'd2 : r;
  endfunction

endpackage

// File: rtl/dcar_cfg_hold.sv
module dcar_cfg_hold
  import dcar_pkg::*;
#(
  parameter int LOG_W = 6,
  parameter int CAP_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drained,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       ranks0_i,
  input  logic [LOG_W-1:0] log0_i,
  input  logic [1:0]       ranks1_i,
  input  logic [LOG_W-1:0] log1_i,
  output map_e             map_o,
  output logic [1:0]       ranks0_o,
  output logic [LOG_W-1:0] log0_o,
  output logic [1:0]       ranks1_o,
  output logic [LOG_W-1:0] log1_o,
  output logic [CAP_W-1:0] cap0_o,
  output logic [CAP_W-1:0] cap1_o,
  output logic             fallback_o
);

  function automatic logic [CAP_W-1:0] cap_of(input logic [1:0] r, input logic [LOG_W-1:0] lg);
    logic [CAP_W-1:0] one;
    one = CAP_W'(1);
    case (r)
      2'd1:    return one << lg;
      2'd2:    return one << (lg + 1'b1);
      default: return '0;
    endcase
  endfunction

  logic [1:0]       mode_q, mode_eff;
  logic [1:0]       r0_q, r1_q, r0_eff, r1_eff;
  logic [LOG_W-1:0] l0_q, l1_q, l0_eff, l1_eff;
  logic             mismatch;
  logic             fallback_q;

  // Live pins when idle, held copy while any stage is occupied.
  always_comb begin
    mode_eff = drained ? mode_i : mode_q;
    r0_eff   = drained ? clip_ranks(ranks0_i) : r0_q;
    r1_eff   = drained ? clip_ranks(ranks1_i) : r1_q;
    l0_eff   = drained ? log0_i : l0_q;
    l1_eff   = drained ? log1_i : l1_q;
  end

  assign cap0_o   = cap_of(r0_eff, l0_eff);
  assign cap1_o   = cap_of(r1_eff, l1_eff);
  assign mismatch = (map_from_pins(mode_eff) == MAP_INTLV) && (cap0_o != cap1_o);
  assign map_o    = mismatch ? MAP_LINEAR : map_from_pins(mode_eff);
  assign ranks0_o = r0_eff;
  assign ranks1_o = r1_eff;
  assign log0_o   = l0_eff;
  assign log1_o   = l1_eff;
  assign fallback_o = fallback_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      r0_q       <= '0;
      r1_q       <= '0;
      l0_q       <= '0;
      l1_q       <= '0;
      fallback_q <= 1'b0;
    end else begin
      mode_q     <= mode_eff;
      r0_q       <= r0_eff;
      r1_q       <= r1_eff;
      l0_q       <= l0_eff;
      l1_q       <= l1_eff;
      fallback_q <= fallback_q | mismatch;
    end
  end

endmodule

// File: rtl/dcar_decode.sv
module dcar_decode
  import dcar_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LOG_W     = 6,
  parameter int CAP_W     = 34,
  parameter int LINE_BITS = 6
) (
  input  map_e              map_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ranks0_i,
  input  logic [LOG_W-1:0]  log0_i,
  input  logic [1:0]        ranks1_i,
  input  logic [LOG_W-1:0]  log1_i,
  input  logic [CAP_W-1:0]  cap0_i,
  input  logic [CAP_W-1:0]  cap1_i,
  output logic              oor_o,
  output logic              ch_o,
  output logic [ADDR_W-1:0] loc_o,
  output logic [1:0]        cs_o
);

  localparam logic [ADDR_W-1:0] LINE_MASK = (ADDR_W'(1) << LINE_BITS) - ADDR_W'(1);

  // Drop the channel-select bit: upper part moves down one place.
  function automatic logic [ADDR_W-1:0] squeeze(input logic [ADDR_W-1:0] a);
    return ((a >> (LINE_BITS + 1)) << LINE_BITS) | (a & LINE_MASK);
  endfunction

  function automatic logic [1:0] rank_cs(input logic [1:0] r, input logic [LOG_W-1:0] lg,
                                         input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] shifted;
    shifted = a >> lg;
    return ((r == 2'd2) && shifted[0]) ? 2'b10 : 2'b01;
  endfunction

  logic [CAP_W-1:0] addr_x;
  logic [CAP_W-1:0] total;

  always_comb begin
    addr_x = CAP_W'(addr_i);
    total  = (map_i == MAP_SINGLE) ? cap0_i : (cap0_i + cap1_i);
    oor_o  = (addr_x >= total);
    case (map_i)
      MAP_INTLV: begin
        ch_o  = addr_i[LINE_BITS];
        loc_o = squeeze(addr_i);
      end
      MAP_LINEAR: begin
        ch_o  = (addr_x >= cap0_i);
        loc_o = ch_o ? ADDR_W'(addr_x - cap0_i) : addr_i;
      end
      default: begin
        ch_o  = 1'b0;
        loc_o = addr_i;
      end
    endcase
    cs_o = ch_o ? rank_cs(ranks1_i, log1_i, loc_o) : rank_cs(ranks0_i, log0_i, loc_o);
  end

endmodule

// File: rtl/dcar_out_stage.sv
module dcar_out_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cs_i,
  output logic              free_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        cs_o
);

  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      cs_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      cs_o    <= cs_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
      cs_o    <= '0;
    end
  end

endmodule

// File: rtl/dual_channel_addr_router.sv
module dual_channel_addr_router
  import dcar_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LOG_W     = 6,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_ch0_ranks,
  input  logic [LOG_W-1:0]  cfg_ch0_rank_log2,
  input  logic [1:0]        cfg_ch1_ranks,
  input  logic [LOG_W-1:0]  cfg_ch1_rank_log2,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              ch0_valid,
  input  logic              ch0_ready,
  output logic [ADDR_W-1:0] ch0_addr,
  output logic [1:0]        ch0_cs,
  output logic              ch1_valid,
  input  logic              ch1_ready,
  output logic [ADDR_W-1:0] ch1_addr,
  output logic [1:0]        ch1_cs,
  output logic              err_pulse,
  output logic              map_fallback
);

  localparam int CAP_W = ADDR_W + 2;
  localparam int NCH   = 2;

  map_e              map_eff;
  logic [1:0]        rk0, rk1;
  logic [LOG_W-1:0]  lg0, lg1;
  logic [CAP_W-1:0]  cap0, cap1;
  logic              drained;
  logic              dec_oor, dec_ch;
  logic [ADDR_W-1:0] dec_addr;
  logic [1:0]        dec_cs;
  logic              accept, drop, err_q;
  logic [NCH-1:0]    stage_free, stage_valid, stage_load, port_ready;
  logic [ADDR_W-1:0] port_addr [NCH];
  logic [1:0]        port_cs   [NCH];

  dcar_cfg_hold #(.LOG_W(LOG_W), .CAP_W(CAP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .drained(drained),
    .mode_i(cfg_mode),
    .ranks0_i(cfg_ch0_ranks), .log0_i(cfg_ch0_rank_log2),
    .ranks1_i(cfg_ch1_ranks), .log1_i(cfg_ch1_rank_log2),
    .map_o(map_eff),
    .ranks0_o(rk0), .log0_o(lg0), .ranks1_o(rk1), .log1_o(lg1),
    .cap0_o(cap0), .cap1_o(cap1), .fallback_o(map_fallback)
  );

  dcar_decode #(.ADDR_W(ADDR_W), .LOG_W(LOG_W), .CAP_W(CAP_W), .LINE_BITS(LINE_BITS)) u_dec (
    .map_i(map_eff), .addr_i(in_addr),
    .ranks0_i(rk0), .log0_i(lg0), .ranks1_i(rk1), .log1_i(lg1),
    .cap0_i(cap0), .cap1_i(cap1),
    .oor_o(dec_oor), .ch_o(dec_ch), .loc_o(dec_addr), .cs_o(dec_cs)
  );

  // Out-of-range requests never wait; others wait only on their own channel.
  assign in_ready   = dec_oor | stage_free[dec_ch];
  assign accept     = in_valid & in_ready;
  assign drop       = accept & dec_oor;
  assign drained    = ~|stage_valid;
  assign port_ready = {ch1_ready, ch0_ready};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign stage_load[c] = accept & ~dec_oor & (dec_ch == 1'(c));
    dcar_out_stage #(.ADDR_W(ADDR_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .load_i(stage_load[c]), .addr_i(dec_addr), .cs_i(dec_cs),
      .free_o(stage_free[c]), .valid_o(stage_valid[c]), .ready_i(port_ready[c]),
      .addr_o(port_addr[c]), .cs_o(port_cs[c])
    );
  end

  assign ch0_valid = stage_valid[0];
  assign ch0_addr  = port_addr[0];
  assign ch0_cs    = port_cs[0];
  assign ch1_valid = stage_valid[1];
  assign ch1_addr  = port_addr[1];
  assign ch1_cs    = port_cs[1];
  assign err_pulse = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= drop;
  end

endmodule

// File: rtl/dcar_checker.sv
module dcar_checker #(
  parameter int ADDR_W = 32,
  parameter int CAP_W  = ADDR_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ch0_valid,
  input logic              ch0_ready,
  input logic [ADDR_W-1:0] ch0_addr,
  input logic [1:0]        ch0_cs,
  input logic              ch1_valid,
  input logic              ch1_ready,
  input logic [ADDR_W-1:0] ch1_addr,
  input logic [1:0]        ch1_cs,
  input logic              err_pulse,
  input logic              map_fallback,
  input logic [CAP_W-1:0]  cap0,
  input logic [CAP_W-1:0]  cap1,
  input logic              drained
);

  a_r6_cs_one_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_valid |-> $countones(ch0_cs) == 1);
  a_r6_cs_one_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid |-> $countones(ch1_cs) == 1);
  a_r11_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch0_valid |-> ch0_cs == 2'b00) and (!ch1_valid |-> ch1_cs == 2'b00));
  a_r9_hold_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_valid && !ch0_ready |=> ch0_valid && $stable(ch0_addr) && $stable(ch0_cs));
  a_r9_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid && !ch1_ready |=> ch1_valid && $stable(ch1_addr) && $stable(ch1_cs));
  a_r12_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch0_valid) || $rose(ch1_valid)) |-> $past(in_valid && in_ready));
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid && in_ready));
  a_r8_err_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !$rose(ch0_valid) && !$rose(ch1_valid));
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    map_fallback |=> map_fallback);
  a_r7_in_cap0: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_valid |-> CAP_W'(ch0_addr) < cap0);
  a_r7_in_cap1: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid |-> CAP_W'(ch1_addr) < cap1);
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !drained |-> $stable(cap0) && $stable(cap1));

endmodule

bind dual_channel_addr_router dcar_checker u_dcar_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .ch0_valid(ch0_valid), .ch0_ready(ch0_ready), .ch0_addr(ch0_addr), .ch0_cs(ch0_cs),
  .ch1_valid(ch1_valid), .ch1_ready(ch1_ready), .ch1_addr(ch1_addr), .ch1_cs(ch1_cs),
  .err_pulse(err_pulse), .map_fallback(map_fallback),
  .cap0(cap0), .cap1(cap1), .drained(drained)
);

// File: tb/dual_channel_addr_router_bench.sv
module dual_channel_addr_router_bench;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  r0;
    logic [5:0]  l0;
    logic [1:0]  r1;
    logic [5:0]  l1;
    logic [31:0] addr;
    logic        err;
    logic        ch;
    logic [31:0] loc;
    logic [1:0]  cs;
    int unsigned req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd2, 6'd10, 2'd2, 6'd10, 32'h040,  1'b0, 1'b1, 32'h000, 2'b01, 1},  // R1
    '{2'd0, 2'd2, 6'd10, 2'd2, 6'd10, 32'h0BC,  1'b0, 1'b0, 32'h07C, 2'b01, 1},  // R1
    '{2'd0, 2'd2, 6'd10, 2'd2, 6'd10, 32'h0C5,  1'b0, 1'b1, 32'h045, 2'b01, 1},  // R1
    '{2'd0, 2'd2, 6'd10, 2'd2, 6'd10, 32'hFFF,  1'b0, 1'b1, 32'h7FF, 2'b10, 6},  // R6
    '{2'd0, 2'd2, 6'd10, 2'd2, 6'd10, 32'h1000, 1'b1, 1'b0, 32'h000, 2'b00, 8},  // R8
    '{2'd1, 2'd2, 6'd10, 2'd2, 6'd10, 32'h7FF,  1'b0, 1'b0, 32'h7FF, 2'b10, 3},  // R3
    '{2'd1, 2'd2, 6'd10, 2'd2, 6'd10, 32'h800,  1'b0, 1'b1, 32'h000, 2'b01, 3},  // R3
    '{2'd1, 2'd2, 6'd10, 2'd2, 6'd10, 32'hC40,  1'b0, 1'b1, 32'h440, 2'b10, 3},  // R3
    '{2'd1, 2'd2, 6'd10, 2'd0, 6'd10, 32'h500,  1'b0, 1'b0, 32'h500, 2'b10, 4},  // R4
    '{2'd1, 2'd2, 6'd10, 2'd0, 6'd10, 32'h800,  1'b1, 1'b0, 32'h000, 2'b00, 4},  // R4
    '{2'd2, 2'd1, 6'd10, 2'd2, 6'd10, 32'h3C0,  1'b0, 1'b0, 32'h3C0, 2'b01, 5},  // R5
    '{2'd2, 2'd1, 6'd10, 2'd2, 6'd10, 32'h400,  1'b1, 1'b0, 32'h000, 2'b00, 5},  // R5
    '{2'd0, 2'd2, 6'd10, 2'd1, 6'd10, 32'h840,  1'b0, 1'b1, 32'h040, 2'b01, 2},  // R2
    '{2'd0, 2'd2, 6'd10, 2'd1, 6'd10, 32'h440,  1'b0, 1'b0, 32'h440, 2'b10, 2},  // R2
    '{2'd3, 2'd2, 6'd10, 2'd2, 6'd10, 32'h7C0,  1'b0, 1'b0, 32'h7C0, 2'b10, 5},  // R5
    '{2'd1, 2'd3, 6'd10, 2'd2, 6'd10, 32'hA00,  1'b0, 1'b1, 32'h200, 2'b01, 7},  // R7
    '{2'd1, 2'd2, 6'd9,  2'd2, 6'd10, 32'h500,  1'b0, 1'b1, 32'h100, 2'b01, 7}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_ch0_ranks = 2'd2;
  logic [5:0]  cfg_ch0_rank_log2 = 6'd10;
  logic [1:0]  cfg_ch1_ranks = 2'd2;
  logic [5:0]  cfg_ch1_rank_log2 = 6'd10;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        ch0_valid, ch1_valid;
  logic        ch0_ready = 1'b1, ch1_ready = 1'b1;
  logic [31:0] ch0_addr, ch1_addr;
  logic [1:0]  ch0_cs, ch1_cs;
  logic        err_pulse, map_fallback;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_channel_addr_router u_dual_channel_addr_router (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_ch0_ranks(cfg_ch0_ranks), .cfg_ch0_rank_log2(cfg_ch0_rank_log2),
    .cfg_ch1_ranks(cfg_ch1_ranks), .cfg_ch1_rank_log2(cfg_ch1_rank_log2),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .ch0_valid(ch0_valid), .ch0_ready(ch0_ready), .ch0_addr(ch0_addr), .ch0_cs(ch0_cs),
    .ch1_valid(ch1_valid), .ch1_ready(ch1_ready), .ch1_addr(ch1_addr), .ch1_cs(ch1_cs),
    .err_pulse(err_pulse), .map_fallback(map_fallback)
  );

  task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] r0, input logic [5:0] l0,
                         input logic [1:0] r1, input logic [5:0] l1);
    cfg_mode = m; cfg_ch0_ranks = r0; cfg_ch0_rank_log2 = l0;
    cfg_ch1_ranks = r1; cfg_ch1_rank_log2 = l1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got=expired expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] got, exp;
    // Reset state (R11)
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 64'({ch0_valid, ch1_valid, ch0_cs, ch1_cs, err_pulse, map_fallback}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: one request, result sampled one cycle later (R12), then drain.
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].mode, VEC[i].r0, VEC[i].l0, VEC[i].r1, VEC[i].l1);
      in_addr  = VEC[i].addr;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      got = {err_pulse, ch0_valid, ch1_valid, 27'd0,
             ch1_valid ? ch1_addr : (ch0_valid ? ch0_addr : 32'd0), ch0_cs | ch1_cs};
      exp = {VEC[i].err, !VEC[i].err && !VEC[i].ch, !VEC[i].err && VEC[i].ch, 27'd0,
             VEC[i].err ? 32'd0 : VEC[i].loc, VEC[i].err ? 2'b00 : VEC[i].cs};
      check($sformatf("R%0d R12 vector %0d", VEC[i].req, i), got, exp);
      if (i == 11) check("R2 no fallback on equal sizes", 64'(map_fallback), 64'd0);
      @(negedge clk);
    end
    check("R2 fallback sticky", 64'(map_fallback), 64'd1);

    // Error pulse lasts one cycle (R8)
    set_cfg(2'd1, 2'd2, 6'd10, 2'd2, 6'd10);
    in_addr = 32'h2000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 err high", 64'({err_pulse, ch0_valid, ch1_valid}), 64'b100);
    @(negedge clk);
    check("R8 err one cycle", 64'(err_pulse), 64'd0);

    // Stall on channel 1, held configuration (R9, R10)
    set_cfg(2'd0, 2'd2, 6'd10, 2'd2, 6'd10);
    ch1_ready = 1'b0;
    in_addr = 32'h040; in_valid = 1'b1;
    @(negedge clk);
    in_addr = 32'h0C0;
    cfg_mode = 2'd1;
    check("R9 blocked same channel", 64'({in_ready, ch1_valid, ch1_addr}), {31'd0, 1'b0, 1'b1, 32'h000});
    @(negedge clk);
    check("R9 stalled output stable", 64'({in_ready, ch1_valid, ch1_cs, ch1_addr}), {29'd0, 1'b0, 1'b1, 2'b01, 32'h000});
    ch1_ready = 1'b1;
    #1;
    check("R9 ready follows channel", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 held mapping used", 64'({ch0_valid, ch1_valid, ch1_cs, ch1_addr}), {28'd0, 1'b0, 1'b1, 2'b01, 32'h040});
    @(negedge clk);
    in_addr = 32'h0C0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 new mapping after drain", 64'({ch0_valid, ch1_valid, ch0_addr}), {30'd0, 1'b1, 1'b0, 32'h0C0});
    @(negedge clk);

    // Other channel not blocked by a stall (R9)
    cfg_mode = 2'd0;
    ch1_ready = 1'b0;
    in_addr = 32'h040; in_valid = 1'b1;
    @(negedge clk);
    in_addr = 32'h080;
    #1;
    check("R9 other channel free", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 ch0 passes stall", 64'({ch0_valid, ch1_valid, ch0_addr}), {30'd0, 1'b1, 1'b1, 32'h040});
    // Out-of-range accepted while channel 1 is stalled (R8)
    in_addr = 32'h4000; in_valid = 1'b1;
    #1;
    check("R8 ready on out-of-range", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 err while stalled", 64'({err_pulse, ch1_addr}), {31'd0, 1'b1, 32'h000});
    ch1_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Mid-run reset clears the sticky flag (R11)
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset clears flag", 64'({map_fallback, ch0_valid, ch1_valid, err_pulse}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule